// File: doc/BRIEF.md
# Descriptor-Driven Configuration DMA Engine

This engine moves bytes from a keyed configuration item port into system memory without the host having to read the item one byte at a time. Software places a 16-byte access descriptor in memory and writes that descriptor's physical address into a 64-bit big-endian address register. A write to the low (least significant) half of that register launches the operation. A 64-bit address is loaded as two 32-bit writes, high half first.

The engine fetches the descriptor as four big-endian words. It applies an optional item selection, then either streams `length` item bytes into memory at the target address, or advances the item offset by `length`. It then overwrites the descriptor's control word with a completion status and clears the address register. One descriptor is handled at a time.

The controller walks these states: `ST_IDLE` goes to `ST_FETCH_REQ` on a start. `ST_FETCH_REQ` goes to `ST_FETCH_RSP` when the request is accepted. `ST_FETCH_RSP` goes back to `ST_FETCH_REQ` for the next word, to `ST_APPLY` after the fourth word, or to `ST_STAT_REQ` on a bus error. `ST_APPLY` issues the select and skip strobes and goes to `ST_DATA_REQ` when a read has a nonzero length, or to `ST_STAT_REQ` otherwise. `ST_DATA_REQ` goes to `ST_DATA_RSP` on acceptance. `ST_DATA_RSP` goes back to `ST_DATA_REQ` for the next byte, or to `ST_STAT_REQ` after the last byte or an error. `ST_STAT_REQ` goes to `ST_STAT_RSP` on acceptance. `ST_STAT_RSP` returns to `ST_IDLE` on the response.

Top module: `cfgdma_engine`

## Requirements
- R1: The address register resets to 0. A write with `reg_wr_lo`=0 loads bits 63:32 and a write with `reg_wr_lo`=1 loads bits 31:0; `dma_addr` shows the new value one cycle after the write.
- R2: A low-half write while idle starts an operation and `busy` is high the next cycle. A high-half write never starts one.
- R3: The descriptor is fetched as four word reads at base+0, +4, +8, +12. Each word is big-endian in memory (the byte at the lowest address is bits 31:24). The words are, in order: control, length, target address bits 63:32, target address bits 31:0.
- R4: When control bit 3 is set, a select strobe carries control bits 31:16 as the item key. The item offset restarts at 0 before any read or skip of the same descriptor.
- R5: When control bit 1 is set and the length is nonzero, byte i (0 ≤ i < length) of the item, taken from the current offset, is written to target+i as a byte write. The item offset advances by exactly length, and no byte beyond target+length-1 is written.
- R6: When control bit 2 is set and bit 1 is clear, one skip strobe advances the item offset by length and no data byte is written.
- R7: On completion the control word at base+0 is overwritten with 0 on success. In the same cycle `busy` falls and the address register reads 0.
- R8: A bus error response during the descriptor fetch or a data byte write ends the operation. On a data write error the control word becomes 1 (error bit 0 set).
- R9: Register writes while `busy` is high are ignored: they neither change the address register nor start another operation.
- R10: A length of zero writes no data, issues no skip and completes with status 0, while a requested select is still applied.
- R11: A memory request that is not accepted keeps its valid, address, direction and data unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Address register write strobe |
| reg_wr_lo | input | 1 | 1: low half (offset 4, starts), 0: high half (offset 0) |
| reg_wr_data | input | 32 | Write data for the selected half |
| dma_addr | output | 64 | Current address register value |
| busy | output | 1 | Operation in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1: write, 0: read |
| mem_req_word | output | 1 | 1: 32-bit big-endian word, 0: single byte (wdata bits 7:0) |
| mem_req_addr | output | 64 | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response for the accepted request |
| mem_rsp_err | input | 1 | Response carries a bus error |
| mem_rsp_rdata | input | 32 | Read data (word value) |
| cfg_select | output | 1 | Select strobe: load key, offset to 0 (applied before a same-cycle skip) |
| cfg_key | output | 16 | Key for the select strobe |
| cfg_skip | output | 1 | Skip strobe: offset += cfg_skip_len |
| cfg_skip_len | output | 32 | Skip length |
| cfg_next | output | 1 | Consume the current item byte, offset += 1 |
| cfg_byte | input | 8 | Item byte at the current offset |

## Verification
Register loads appear on `dma_addr` one cycle after the write edge. `busy` rises one cycle after a low-half write. Status, target bytes, item offset and the cleared register are all final in the cycle in which `busy` falls, because the last status response and the register clear land on the same edge. The bench drives every input on the falling edge and samples on the falling edge. After a start it checks `busy` at the very next sample, then polls until `busy` is low and compares memory and the item model against values computed from the descriptor it wrote. Random back-pressure on the memory port varies the completion cycle, so no check depends on a fixed latency beyond those two one-cycle relations.

// File: rtl/cfgdma_pkg.sv
package cfgdma_pkg;
    localparam int ADDR_W = 64;
    localparam int WORD_W = 32;
    localparam int KEY_W  = 16;
    localparam int BYTE_W = 8;
    localparam int DESC_WORDS = 4;
    localparam int WCNT_W = $clog2(DESC_WORDS);

    localparam int CTL_READ = 1;
    localparam int CTL_SKIP = 2;
    localparam int CTL_SEL  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_REQ,
        ST_FETCH_RSP,
        ST_APPLY,
        ST_DATA_REQ,
        ST_DATA_RSP,
        ST_STAT_REQ,
        ST_STAT_RSP
    } state_t;
endpackage

// File: rtl/cfgdma_addr_reg.sv
module cfgdma_addr_reg
    import cfgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_lo,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              busy,
    input  logic              done,
    output logic [ADDR_W-1:0] addr_q,
    output logic              start
);
    logic accept;

    assign accept = wr_en && !busy;
    assign start  = accept && wr_lo;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (done) begin
            addr_q <= '0;
        end else if (accept) begin
            if (wr_lo) addr_q[WORD_W-1:0]      <= wr_data;
            else       addr_q[ADDR_W-1:WORD_W] <= wr_data;
        end
    end

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (addr_q == $past(addr_q)));

    // R7
    clear_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (addr_q == '0));
endmodule

// File: rtl/cfgdma_fsm.sv
module cfgdma_fsm
    import cfgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    output logic              busy,
    output logic              done,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic              mem_req_word,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [WORD_W-1:0] mem_rsp_rdata,
    output logic              cfg_select,
    output logic [KEY_W-1:0]  cfg_key,
    output logic              cfg_skip,
    output logic [WORD_W-1:0] cfg_skip_len,
    output logic              cfg_next,
    input  logic [BYTE_W-1:0] cfg_byte
);
    localparam logic [WCNT_W-1:0] WCNT_LAST = WCNT_W'(DESC_WORDS - 1);

    state_t              state_q, state_d;
    logic [WCNT_W-1:0]   wcnt_q;
    logic                sel_q, rd_q, sk_q, err_q;
    logic [KEY_W-1:0]    key_q;
    logic [WORD_W-1:0]   len_q, bcnt_q;
    logic [ADDR_W-1:0]   dst_q;
    logic                do_read, do_skip, last_byte;

    assign do_read   = rd_q && (len_q != '0);
    assign do_skip   = sk_q && !rd_q && (len_q != '0);
    assign last_byte = (bcnt_q == len_q - WORD_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_FETCH_REQ;
            ST_FETCH_REQ: if (mem_req_ready) state_d = ST_FETCH_RSP;
            ST_FETCH_RSP: if (mem_rsp_valid) begin
                if (mem_rsp_err)            state_d = ST_STAT_REQ;
                else if (wcnt_q == WCNT_LAST) state_d = ST_APPLY;
                else                        state_d = ST_FETCH_REQ;
            end
            ST_APPLY:     state_d = do_read ? ST_DATA_REQ : ST_STAT_REQ;
            ST_DATA_REQ:  if (mem_req_ready) state_d = ST_DATA_RSP;
            ST_DATA_RSP:  if (mem_rsp_valid) begin
                if (mem_rsp_err || last_byte) state_d = ST_STAT_REQ;
                else                          state_d = ST_DATA_REQ;
            end
            ST_STAT_REQ:  if (mem_req_ready) state_d = ST_STAT_RSP;
            ST_STAT_RSP:  if (mem_rsp_valid) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            sel_q  <= 1'b0;
            rd_q   <= 1'b0;
            sk_q   <= 1'b0;
            err_q  <= 1'b0;
            key_q  <= '0;
            len_q  <= '0;
            bcnt_q <= '0;
            dst_q  <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                wcnt_q <= '0;
                err_q  <= 1'b0;
                bcnt_q <= '0;
                sel_q  <= 1'b0;
                rd_q   <= 1'b0;
                sk_q   <= 1'b0;
            end
            if (state_q == ST_FETCH_RSP && mem_rsp_valid) begin
                if (mem_rsp_err) begin
                    err_q <= 1'b1;
                end else begin
                    wcnt_q <= wcnt_q + WCNT_W'(1);
                    case (wcnt_q)
                        2'd0: begin
                            key_q <= mem_rsp_rdata[WORD_W-1 -: KEY_W];
                            sel_q <= mem_rsp_rdata[CTL_SEL];
                            rd_q  <= mem_rsp_rdata[CTL_READ];
                            sk_q  <= mem_rsp_rdata[CTL_SKIP];
                        end
                        2'd1:    len_q <= mem_rsp_rdata;
                        2'd2:    dst_q[ADDR_W-1:WORD_W] <= mem_rsp_rdata;
                        default: dst_q[WORD_W-1:0] <= mem_rsp_rdata;
                    endcase
                end
            end
            if (state_q == ST_DATA_RSP && mem_rsp_valid) begin
                if (mem_rsp_err) err_q  <= 1'b1;
                else             bcnt_q <= bcnt_q + WORD_W'(1);
            end
        end
    end

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_word  = 1'b1;
        mem_req_addr  = base;
        mem_req_wdata = '0;
        cfg_select    = 1'b0;
        cfg_skip      = 1'b0;
        cfg_next      = 1'b0;
        done          = 1'b0;
        unique case (state_q)
            ST_FETCH_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = base + ADDR_W'({wcnt_q, 2'b00});
            end
            ST_APPLY: begin
                cfg_select = sel_q;
                cfg_skip   = do_skip;
            end
            ST_DATA_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_word  = 1'b0;
                mem_req_addr  = dst_q + ADDR_W'(bcnt_q);
                mem_req_wdata = WORD_W'(cfg_byte);
                cfg_next      = mem_req_ready;
            end
            ST_STAT_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_wdata = WORD_W'(err_q);
            end
            ST_STAT_RSP: done = mem_rsp_valid;
            default: ;
        endcase
    end

    assign busy         = (state_q != ST_IDLE);
    assign cfg_key      = key_q;
    assign cfg_skip_len = len_q;

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write) && $stable(mem_req_wdata)));

    // R2
    start_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && mem_req_valid && !mem_req_write));

    // R7
    status_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && mem_req_word) |-> (mem_req_wdata[WORD_W-1:1] == '0));

    // R6
    skip_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_skip |=> !(mem_req_valid && mem_req_write && !mem_req_word));
endmodule

// File: rtl/cfgdma_engine.sv
module cfgdma_engine
    import cfgdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_wr_lo,
    input  logic [WORD_W-1:0] reg_wr_data,
    output logic [ADDR_W-1:0] dma_addr,
    output logic              busy,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic              mem_req_word,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [WORD_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [WORD_W-1:0] mem_rsp_rdata,
    output logic              cfg_select,
    output logic [KEY_W-1:0]  cfg_key,
    output logic              cfg_skip,
    output logic [WORD_W-1:0] cfg_skip_len,
    output logic              cfg_next,
    input  logic [BYTE_W-1:0] cfg_byte
);
    logic start, done;

    cfgdma_addr_reg u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr_en),
        .wr_lo   (reg_wr_lo),
        .wr_data (reg_wr_data),
        .busy    (busy),
        .done    (done),
        .addr_q  (dma_addr),
        .start   (start)
    );

    cfgdma_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .base          (dma_addr),
        .busy          (busy),
        .done          (done),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_word  (mem_req_word),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_err   (mem_rsp_err),
        .mem_rsp_rdata (mem_rsp_rdata),
        .cfg_select    (cfg_select),
        .cfg_key       (cfg_key),
        .cfg_skip      (cfg_skip),
        .cfg_skip_len  (cfg_skip_len),
        .cfg_next      (cfg_next),
        .cfg_byte      (cfg_byte)
    );
endmodule

// File: tb/tb_cfgdma_engine.sv
module tb_cfgdma_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_wr_lo = 1'b0;
    logic [31:0] reg_wr_data = '0;
    logic [63:0] dma_addr;
    logic        busy;
    logic        mem_req_valid, mem_req_write, mem_req_word;
    logic        mem_req_ready = 1'b0;
    logic [63:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;
    logic        cfg_select, cfg_skip, cfg_next;
    logic [15:0] cfg_key;
    logic [31:0] cfg_skip_len;
    logic [7:0]  cfg_byte;

    int n_chk = 0, n_fail = 0, hold_viol = 0;

    always #5 clk = ~clk;

    cfgdma_engine dut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_lo(reg_wr_lo),
        .reg_wr_data(reg_wr_data), .dma_addr(dma_addr), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_word(mem_req_word),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
        .mem_rsp_rdata(mem_rsp_rdata), .cfg_select(cfg_select), .cfg_key(cfg_key),
        .cfg_skip(cfg_skip), .cfg_skip_len(cfg_skip_len), .cfg_next(cfg_next),
        .cfg_byte(cfg_byte)
    );

    function automatic logic [7:0] item_fn(input logic [15:0] k, input logic [31:0] o);
        return k[7:0] ^ k[15:8] ^ (o[7:0] * 8'd7) ^ 8'h5A;
    endfunction

    // configuration item model
    logic [15:0] it_key = '0;
    logic [31:0] it_off = '0;
    assign cfg_byte = item_fn(it_key, it_off);
    always @(posedge clk) begin
        it_key <= cfg_select ? cfg_key : it_key;
        it_off <= (cfg_select ? 32'd0 : it_off) + (cfg_skip ? cfg_skip_len : 32'd0)
                  + (cfg_next ? 32'd1 : 32'd0);
    end

    // memory model: addresses with bits 63:8 nonzero answer with a bus error
    logic [7:0]  mem [0:255];
    logic        h_we = 1'b0;
    logic [7:0]  h_a = '0;
    logic [31:0] h_w = '0;
    always @(negedge clk) mem_req_ready <= ($urandom_range(3) != 0);
    always @(posedge clk) begin
        mem_rsp_valid <= 1'b0;
        mem_rsp_err   <= 1'b0;
        if (h_we) begin
            mem[h_a] <= h_w[31:24]; mem[h_a + 8'd1] <= h_w[23:16];
            mem[h_a + 8'd2] <= h_w[15:8]; mem[h_a + 8'd3] <= h_w[7:0];
        end
        if (rst_n && mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            if (mem_req_addr[63:8] != '0) begin
                mem_rsp_err <= 1'b1;
            end else if (mem_req_write && mem_req_word) begin
                mem[mem_req_addr[7:0]]         <= mem_req_wdata[31:24];
                mem[mem_req_addr[7:0] + 8'd1]  <= mem_req_wdata[23:16];
                mem[mem_req_addr[7:0] + 8'd2]  <= mem_req_wdata[15:8];
                mem[mem_req_addr[7:0] + 8'd3]  <= mem_req_wdata[7:0];
            end else if (mem_req_write) begin
                mem[mem_req_addr[7:0]] <= mem_req_wdata[7:0];
            end else begin
                mem_rsp_rdata <= {mem[mem_req_addr[7:0]], mem[mem_req_addr[7:0] + 8'd1],
                                  mem[mem_req_addr[7:0] + 8'd2], mem[mem_req_addr[7:0] + 8'd3]};
            end
        end
    end

    // R11 monitor: an unaccepted request must persist unchanged
    logic        p_stall = 1'b0, p_wr = 1'b0;
    logic [63:0] p_addr = '0;
    logic [31:0] p_data = '0;
    always @(posedge clk) begin
        if (rst_n && p_stall && (!mem_req_valid || mem_req_addr != p_addr ||
            mem_req_write != p_wr || mem_req_wdata != p_data))
            hold_viol <= hold_viol + 1;
        p_stall <= rst_n && mem_req_valid && !mem_req_ready;
        p_addr <= mem_req_addr; p_wr <= mem_req_write; p_data <= mem_req_wdata;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd_word(input logic [7:0] a);
        return {mem[a], mem[a + 8'd1], mem[a + 8'd2], mem[a + 8'd3]};
    endfunction

    task automatic poke(input logic [7:0] a, input logic [31:0] w);
        h_we = 1'b1; h_a = a; h_w = w;
        @(negedge clk);
        h_we = 1'b0;
    endtask

    task automatic reg_wr(input logic lo, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_wr_lo = lo; reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // one descriptor at desc, expected status exp_st
    task automatic run_desc(input logic [7:0] desc, input logic [31:0] ctrl,
                            input logic [31:0] len, input logic [63:0] dst,
                            input logic [31:0] exp_st, input logic [31:0] exp_adv_err);
        logic [15:0] ek;
        logic [31:0] eo;
        logic        rd, sk;
        poke(desc, ctrl); poke(desc + 8'd4, len);
        poke(desc + 8'd8, dst[63:32]); poke(desc + 8'd12, dst[31:0]);
        for (int i = 0; i < 16; i += 4) poke(dst[7:0] + 8'(i), 32'hEEEEEEEE);
        rd = ctrl[1]; sk = ctrl[2];
        ek = ctrl[3] ? ctrl[31:16] : it_key;
        eo = ctrl[3] ? 32'd0 : it_off;
        reg_wr(1'b0, 32'd0);
        reg_wr(1'b1, {24'd0, desc});
        check("R2 busy after start", busy, 1);
        wait_idle();
        check("R7 busy low", busy, 0);
        check("R7 register cleared", dma_addr, 0);
        check("R7/R8 status word", rd_word(desc), exp_st);
        check("R4 item key", it_key, ek);
        if (exp_st != 0) begin
            check("R8 offset after error", it_off, eo + exp_adv_err);
        end else if (rd && len != 0) begin
            for (int i = 0; i < int'(len); i++)
                check("R3/R5 data byte", mem[dst[7:0] + 8'(i)], item_fn(ek, eo + 32'(i)));
            check("R5 no overrun", mem[dst[7:0] + len[7:0]], 8'hEE);
            check("R5 offset", it_off, eo + len);
        end else begin
            check("R6/R10 no data", mem[dst[7:0]], 8'hEE);
            check("R6/R10 offset", it_off, (sk && len != 0) ? eo + len : eo);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", dma_addr, 0);
        check("R2 idle after reset", busy, 0);
        check("R11 no request after reset", mem_req_valid, 0);

        // R1/R2: high half loads, no start; then fetch error (R8) path
        poke(8'h20, 32'h0000_0002);
        reg_wr(1'b0, 32'h1234_5678);
        check("R1 high half", dma_addr, 64'h1234_5678_0000_0000);
        check("R2 no start on high", busy, 0);
        reg_wr(1'b1, 32'h0000_0020);
        check("R2 start on low", busy, 1);
        wait_idle();
        check("R8 fetch error ends", busy, 0);
        check("R8 register cleared", dma_addr, 0);
        check("R8 memory untouched", rd_word(8'h20), 32'h0000_0002);

        // R4/R5 directed read with select
        run_desc(8'h00, 32'h00A5_000A, 32'd12, 64'h80, 32'd0, 32'd0);
        // R6 skip
        run_desc(8'h10, 32'h0000_0004, 32'd5, 64'h90, 32'd0, 32'd0);
        // R10 zero length read with select
        run_desc(8'h20, 32'h0033_000B, 32'd0, 64'hA0, 32'd0, 32'd0);
        // R8 data write error: first byte errs, offset advanced by one
        run_desc(8'h30, 32'h0007_000A, 32'd4, 64'h0000_0001_0000_00B0, 32'd1, 32'd1);

        // R9 writes during busy ignored
        poke(8'h40, 32'h0000_0002);
        poke(8'h00, 32'h0011_0002); poke(8'h04, 32'd12);
        poke(8'h08, 32'd0); poke(8'h0C, 32'h0000_00C0);
        reg_wr(1'b0, 32'd0);
        reg_wr(1'b1, 32'h0000_0000);
        reg_wr(1'b0, 32'h0000_0055);
        reg_wr(1'b1, 32'h0000_0040);
        check("R9 register unchanged", dma_addr, 0);
        wait_idle();
        repeat (3) @(negedge clk);
        check("R9 no second op", busy, 0);
        check("R9 register zero", dma_addr, 0);
        check("R9 second descriptor untouched", rd_word(8'h40), 32'h0000_0002);

        // random descriptors
        for (int t = 0; t < 40; t++) begin
            logic [31:0] c;
            c = {16'($urandom), 12'd0, 4'($urandom)};
            run_desc(8'($urandom_range(3) * 16), c, 32'($urandom_range(12)),
                     64'(8'h80 + 8'($urandom_range(8'h60))), 32'd0, 32'd0);
        end

        check("R11 request hold", 64'(hold_viol), 0);
        finish_run();
    end
endmodule